// File: doc/BRIEF.md
# Cascadable Decimal Rate Multiplier

The block divides an input clock by a programmable decimal fraction. A modulo-ten counter steps through ten states, and a 4-bit BCD rate word selects how many of those states produce an output pulse. Over any ten clocks the block emits exactly as many one-clock pulses as the rate word. The pulses are spread over the cycle rather than bunched together. Rate words from 10 to 15 are not decimal digits and are clamped to nine.

Stages chain for multi-digit fractions. In additive chaining, a downstream stage advances only while the upstream stage sits at state nine. The upstream pulse feeds the downstream pass-through input, so the rates add as decimal digits. In multiplicative chaining, a downstream stage advances only on upstream pulses, so the two fractions multiply. Synchronous clear, synchronous preset to nine, a hold input, a pulse enable, a nine flag and a carry flag support both arrangements.

Top module: `bcd_rate_mult`

## Requirements
- R1: With hold_i=0 and strobe_i=1, every run of ten consecutive clocks gives exactly rate_i pulses on pulse_o for rate_i values 0 to 9. Each pulse lasts one clock.
- R2: A rate_i value of 10 to 15 behaves as 9, giving nine pulses per ten clocks.
- R3: The counter steps 0,1,...,9,0 and nine_o is 1 exactly while it holds 9. Nine clocks after a clear, nine_o rises; one clock later it falls.
- R4: clear_i=1 at a clock edge loads 0. It overrides set9_i and hold_i.
- R5: set9_i=1 (with clear_i=0) at a clock edge loads 9, even when hold_i=1.
- R6: While hold_i=1, the counter keeps its value and the stage's own pulses are suppressed.
- R7: While strobe_i=0, the stage produces no pulses of its own, whatever the rate word.
- R8: cascade_i is ORed onto pulse_o. pulse_n_o is always the complement of pulse_o.
- R9: carry_o is 1 exactly when the counter holds 9 and hold_i=0.
- R10: Additive chain. The downstream hold_i is driven by NOT carry_o of the upstream stage, and its cascade_i by the upstream pulse_o. After a common clear, the downstream pulse_o then carries 10*a+b pulses per 100 clocks, where a is the upstream digit and b the downstream digit.
- R11: Multiplicative chain. The downstream hold_i is driven by NOT pulse_o of the upstream stage. After a common clear, the downstream pulse_o then carries a*b pulses per 100 clocks.
- R12: State 9 never produces a pulse of the stage's own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low, counter to 0 |
| clear_i | input | 1 | Synchronous counter clear |
| set9_i | input | 1 | Synchronous preset of the counter to 9 |
| hold_i | input | 1 | Freezes the counter and suppresses own pulses |
| strobe_i | input | 1 | Enables own pulses when 1 |
| cascade_i | input | 1 | Upstream pulse ORed onto the output |
| rate_i | input | 4 | BCD rate word |
| pulse_o | output | 1 | Rate output, one clock per pulse |
| pulse_n_o | output | 1 | Complement of pulse_o |
| nine_o | output | 1 | Counter holds 9 |
| carry_o | output | 1 | Counter at 9 and not held; advances a downstream stage |

## Verification
Every rate word from 0 to 15 is run over a full ten-clock window. This separates correct bit weighting from overlapping or missing weights, and shows the clamp on non-decimal codes. Every digit pair is driven through both an additive and a multiplicative two-stage chain over 100 clocks. The additive case exposes a wrong carry timing. The multiplicative case exposes a counter that advances while held. Directed sequences combine clear, preset, hold, strobe and cascade so that priority errors show up in when nine_o rises.

// File: rtl/bcd_rate_mult_pkg.sv
package bcd_rate_mult_pkg;
  parameter int unsigned CntMod = 10;
  localparam int unsigned CntW = $clog2(CntMod);
  localparam int unsigned DigitW = 4;
  localparam int unsigned TopState = CntMod - 1;
  typedef logic [CntW-1:0] cnt_t;
  typedef logic [DigitW-1:0] digit_t;
endpackage

// File: rtl/rm_decade_counter.sv
module rm_decade_counter
  import bcd_rate_mult_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic set9_i,
  input  logic hold_i,
  output cnt_t cnt_o
);
  cnt_t cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)                      cnt_d = '0;
    else if (set9_i)                  cnt_d = cnt_t'(TopState);
    else if (!hold_i) begin
      if (cnt_q >= cnt_t'(TopState))  cnt_d = '0;
      else                            cnt_d = cnt_q + cnt_t'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rm_rate_gate.sv
module rm_rate_gate
  import bcd_rate_mult_pkg::*;
(
  input  cnt_t   cnt_i,
  input  digit_t rate_i,
  output logic   fire_o
);
  digit_t rate_c;
  logic   w8, w4, w2, w1;

  // non-decimal codes behave as nine
  assign rate_c = (rate_i > digit_t'(9)) ? digit_t'(9) : rate_i;

  // state slots: weight1 {4}, weight2 {2,6}, weight4 {1,3,5,7}, weight8 all but {4,9}
  assign w1 = (cnt_i == cnt_t'(4));
  assign w2 = (cnt_i == cnt_t'(2)) || (cnt_i == cnt_t'(6));
  assign w4 = cnt_i[0] && (cnt_i < cnt_t'(8));
  assign w8 = (cnt_i != cnt_t'(4)) && (cnt_i < cnt_t'(TopState));

  assign fire_o = (rate_c[3] & w8) | (rate_c[2] & w4) | (rate_c[1] & w2) | (rate_c[0] & w1);
endmodule

// File: rtl/bcd_rate_mult.sv
module bcd_rate_mult
  import bcd_rate_mult_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       set9_i,
  input  logic       hold_i,
  input  logic       strobe_i,
  input  logic       cascade_i,
  input  logic [3:0] rate_i,
  output logic       pulse_o,
  output logic       pulse_n_o,
  output logic       nine_o,
  output logic       carry_o
);
  cnt_t cnt;
  logic fire;

  rm_decade_counter u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .set9_i  (set9_i),
    .hold_i  (hold_i),
    .cnt_o   (cnt)
  );

  rm_rate_gate u_gate (
    .cnt_i  (cnt),
    .rate_i (rate_i),
    .fire_o (fire)
  );

  assign nine_o    = (cnt == cnt_t'(TopState));
  assign carry_o   = nine_o & ~hold_i;
  assign pulse_o   = (fire & strobe_i & ~hold_i) | cascade_i;
  assign pulse_n_o = ~pulse_o;
endmodule

// File: rtl/bcd_rate_mult_chk.sv
module bcd_rate_mult_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       clear_i,
  input logic       set9_i,
  input logic       hold_i,
  input logic       strobe_i,
  input logic       cascade_i,
  input logic [3:0] rate_i,
  input logic       pulse_o,
  input logic       pulse_n_o,
  input logic       nine_o,
  input logic       carry_o
);
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !nine_o); // R4
  AST_SET_NINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set9_i && !clear_i) |=> nine_o); // R5
  AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !clear_i && !set9_i) |=> $stable(nine_o)); // R6
  AST_HOLD_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !cascade_i) |-> !pulse_o); // R6
  AST_STROBE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && !cascade_i) |-> !pulse_o); // R7
  AST_CASCADE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cascade_i |-> (pulse_o && !pulse_n_o)); // R8
  AST_CARRY_AT_NINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> (nine_o && !hold_i)); // R9
  AST_NINE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nine_o && !hold_i && !set9_i) |=> !nine_o); // R3
  AST_NINE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nine_o && !cascade_i) |-> !pulse_o); // R12
endmodule

bind bcd_rate_mult bcd_rate_mult_chk u_chk (.*);

// File: tb/tb_bcd_rate_mult.sv
`timescale 1ns/1ps
module tb_bcd_rate_mult;
  logic clk = 0, rst_n = 0;
  logic clr = 0, set9 = 0, hold = 0, strobe = 1, casc = 0;
  logic [3:0] rate = 0, rate_b = 0;
  logic p, pn, nine, carry;
  logic pa, pan, ninea, carrya;
  logic pm, pmn, ninem, carrym;
  int errs = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bcd_rate_mult dut (.clk_i(clk), .rst_ni(rst_n), .clear_i(clr), .set9_i(set9),
    .hold_i(hold), .strobe_i(strobe), .cascade_i(casc), .rate_i(rate),
    .pulse_o(p), .pulse_n_o(pn), .nine_o(nine), .carry_o(carry));
  bcd_rate_mult stg_add (.clk_i(clk), .rst_ni(rst_n), .clear_i(clr), .set9_i(1'b0),
    .hold_i(~carry), .strobe_i(1'b1), .cascade_i(p), .rate_i(rate_b),
    .pulse_o(pa), .pulse_n_o(pan), .nine_o(ninea), .carry_o(carrya));
  bcd_rate_mult stg_mul (.clk_i(clk), .rst_ni(rst_n), .clear_i(clr), .set9_i(1'b0),
    .hold_i(~p), .strobe_i(1'b1), .cascade_i(1'b0), .rate_i(rate_b),
    .pulse_o(pm), .pulse_n_o(pmn), .nine_o(ninem), .carry_o(carrym));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // aligned at negedge; counts pulses over n clocks
  task automatic run(input int n, output int c0, output int ca, output int cm, output int bad_n);
    c0 = 0; ca = 0; cm = 0; bad_n = 0;
    for (int i = 0; i < n; i++) begin
      #1;
      c0 += int'(p); ca += int'(pa); cm += int'(pm);
      if (pn !== ~p) bad_n++;
      @(negedge clk);
    end
  endtask

  task automatic do_clear();
    clr = 1; @(negedge clk); clr = 0;
  endtask

  initial begin
    #2_000_000;
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int c0, ca, cm, bn;
    strobe = 0;
    repeat (2) @(negedge clk);
    #1;
    chk("R3 reset nine_o", int'(nine), 0);
    chk("R8 reset pulse_n_o", int'(pn), 1);
    rst_n = 1;
    @(negedge clk);
    strobe = 1;

    // R1 R2 sweep of all rate words
    for (int r = 0; r < 16; r++) begin
      rate = 4'(r);
      do_clear();
      run(10, c0, ca, cm, bn);
      chk(r > 9 ? "R2 clamp count" : "R1 pulse count", c0, r > 9 ? 9 : r);
      chk("R8 complement", bn, 0);
    end

    // R3 nine timing after clear
    rate = 0;
    do_clear();
    repeat (8) @(negedge clk);
    #1 chk("R3 nine_o before 9", int'(nine), 0);
    @(negedge clk); #1 chk("R3 nine_o at 9", int'(nine), 1);
    chk("R9 carry at 9", int'(carry), 1);
    @(negedge clk); #1 chk("R3 wrap", int'(nine), 0);

    // R6 hold freezes and silences
    rate = 9;
    do_clear();
    run(3, c0, ca, cm, bn);
    hold = 1;
    run(5, c0, ca, cm, bn);
    chk("R6 no pulses under hold", c0, 0);
    hold = 0;
    repeat (5) @(negedge clk);
    #1 chk("R6 counter frozen", int'(nine), 0);
    @(negedge clk); #1 chk("R6 nine after resume", int'(nine), 1);
    chk("R12 no pulse at nine", int'(p), 0);

    // R7 strobe off
    do_clear();
    strobe = 0;
    run(10, c0, ca, cm, bn);
    chk("R7 strobe off count", c0, 0);
    strobe = 1;

    // R8 cascade pass-through
    rate = 0; casc = 1;
    #1 chk("R8 cascade on pulse_o", int'(p), 1);
    chk("R8 cascade pulse_n_o", int'(pn), 0);
    @(negedge clk); casc = 0;

    // R4 clear beats set9 and hold
    clr = 1; set9 = 1; hold = 1;
    @(negedge clk);
    clr = 0; set9 = 0; hold = 0;
    #1 chk("R4 clear priority", int'(nine), 0);
    repeat (9) @(negedge clk);
    #1 chk("R4 count from zero", int'(nine), 1);

    // R5 set9 under hold, R9 carry gated by hold
    @(negedge clk);
    set9 = 1; hold = 1;
    @(negedge clk);
    set9 = 0;
    #1 chk("R5 preset under hold", int'(nine), 1);
    chk("R9 carry held", int'(carry), 0);
    hold = 0;
    #1 chk("R9 carry released", int'(carry), 1);

    // R10 R11 two-stage chains, all digit pairs
    for (int a = 0; a < 10; a++) begin
      for (int b = 0; b < 10; b++) begin
        rate = 4'(a); rate_b = 4'(b);
        do_clear();
        run(100, c0, ca, cm, bn);
        chk("R10 add chain", ca, 10 * a + b);
        chk("R11 multiply chain", cm, a * b);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule